// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

This block is a synthesizable, single-clock model of a pipelined synchronous burst SRAM. Every input is sampled on the rising edge of `clk_i`. An access starts when one of two address strobes is asserted and the device is selected. The access then continues through a burst of four addresses. An on-chip counter generates those addresses, and the advance input steps it. The burst order is either linear or interleaved.

Writes are self-timed and take effect on the edge where they are sampled. A global write enable writes all four byte lanes. A byte-write qualifier lets each lane be written through its own enable. Read data passes through an output register, so it appears one clock after the address was registered. An asynchronous output enable masks the output.

A snooze input puts the block into a low-power hold that keeps the memory contents. Entering the hold takes two cycles, and leaving it takes two cycles of recovery. The pad is modelled as separate `data_i`, `data_o` and `data_vld_o` signals. When `data_vld_o` is low, it stands for the high-impedance state.

Top module: `pipe_burst_sram`

## Requirements
- R1: After `rst_ni` is deasserted and before any access, `data_vld_o` is 0 and `data_o` is 0. Memory contents reset to 0.
- R2: A strobe cycle deselects the device, and no data is output for it, in any of these cases:
  - `ce_ni` is high while `adsc_ni` is low;
  - `ce2_i` is low while a strobe is low;
  - `ce2_ni` is high while a strobe is low.
- R3: `ce2_i` and `ce2_ni` are evaluated only in cycles where a strobe is asserted. In continue and suspend cycles their values have no effect on the burst.
- R4: A start through `adsp_ni` with `ce_ni` low is always a read, and the write inputs have no effect on memory in that cycle. When `ce_ni` is high, `adsp_ni` is ignored.
- R5: A start through `adsc_ni` while `adsp_ni` is high is a write when the write decode selects any lane. Otherwise it is a read.
- R6: Write-enable decode:
  - `gw_ni` low writes all lanes;
  - otherwise, with `bwe_ni` low, each low bit `bw_ni[k]` writes lane k, which occupies `data_i[k*LANE_W +: LANE_W]` (bit 0 is lane A, the lowest lane).
- R7: The cycle is a read when `gw_ni` is high and either `bwe_ni` is high or all `bw_ni` bits are high.
- R8: In a continue or suspend cycle, a write lands at the address that the burst holds after that cycle's advance. After an `adsp_ni` start, a write applies from the following cycle, at the start address when `adv_ni` is high.
- R9: For a read whose address is registered on edge N, `data_o` is valid after edge N+1.
- R10: Burst address order, with the low two address bits taken from the start address and n the advance count modulo 4:
  - `mode_i`=0 gives start+n modulo 4;
  - `mode_i`=1 gives start XOR n.
  - The upper address bits stay fixed.
- R11: `adv_ni` high suspends the burst. The address holds and read data stays valid.
- R12: `oe_ni` high forces `data_vld_o` to 0 and `data_o` to 0 at once, without waiting for a clock edge.
- R13: Snooze timing and behaviour:
  - `zz_i` sampled high on two consecutive edges places the block in hold. Strobes are ignored on the following edges, and the output goes invalid.
  - After `zz_i` is sampled low, two more edges are ignored before an access is accepted.
  - Memory contents are retained across the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Start address |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write qualifier, active low |
| bw_ni | input | LANES | Per-lane write enables, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce2_ni | input | 1 | Secondary chip enable, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| zz_i | input | 1 | Snooze request |
| data_i | input | LANE_W*LANES | Write data |
| data_o | output | LANE_W*LANES | Read data, 0 when not valid |
| data_vld_o | output | 1 | Read data valid (low means high-impedance) |

## Verification
Writes are due on the very edge that samples them. Read data is due after the second edge following the start or continue cycle that registered its address. Deselects and snooze entry clear valid data on that same second edge. The output enable acts within the cycle, with no edge involved. A behavioural reference model in the bench advances on each rising edge in step with the design. Outputs are compared at the falling edge that follows, so each result is checked in exactly the cycle it is due. Stimulus covers both burst orders, suspend, lane-wise writes and all deselect cases. It also tries accesses during hold and recovery, and then reads the memory back.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {ZZ_AWAKE, ZZ_ENTER, ZZ_SLEEP, ZZ_WAKE} zz_state_e;

  localparam int BURST_BITS = 2;

  function automatic logic [BURST_BITS-1:0] burst_step(
    input logic [BURST_BITS-1:0] base,
    input logic [BURST_BITS-1:0] cnt,
    input logic                  interleave
  );
    return interleave ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/pbs_write_dec.sv
module pbs_write_dec #(
  parameter int LANES = 4
) (
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] we_o
);
  always_comb begin
    if (!gw_ni)       we_o = '1;
    else if (!bwe_ni) we_o = ~bw_ni;
    else              we_o = '0;
  end
endmodule

// File: rtl/pbs_snooze.sv
module pbs_snooze import pbs_pkg::*; #(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zz_i,
  output logic blocked_o
);
  localparam int CNT_W = $clog2(ENTER_CYC + EXIT_CYC + 1);

  zz_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ZZ_AWAKE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ZZ_AWAKE: if (zz_i) begin
          state_q <= ZZ_ENTER;
          cnt_q   <= CNT_W'(1);
        end
        ZZ_ENTER: begin
          if (!zz_i) state_q <= ZZ_AWAKE;
          else if (int'(cnt_q) >= ENTER_CYC - 1) state_q <= ZZ_SLEEP;
          else cnt_q <= cnt_q + 1'b1;
        end
        ZZ_SLEEP: if (!zz_i) begin
          state_q <= ZZ_WAKE;
          cnt_q   <= CNT_W'(1);
        end
        ZZ_WAKE: begin
          if (zz_i) state_q <= ZZ_SLEEP;
          else if (int'(cnt_q) >= EXIT_CYC - 1) state_q <= ZZ_AWAKE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ZZ_AWAKE;
      endcase
    end
  end

  assign blocked_o = (state_q == ZZ_SLEEP) || (state_q == ZZ_WAKE);

  // entry and exit each take more than one edge
  a_r13_no_instant_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ZZ_AWAKE) |=> (state_q != ZZ_SLEEP));
  a_r13_no_instant_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ZZ_SLEEP) |=> (state_q != ZZ_AWAKE));
endmodule

// File: rtl/pbs_burst_ctr.sv
module pbs_burst_ctr import pbs_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI = ADDR_W - 1;

  logic [ADDR_W-1:0]     base_q, base_nxt;
  logic [BURST_BITS-1:0] cnt_q, cnt_nxt;

  always_comb begin
    base_nxt = load_i ? base_i : base_q;
    if (load_i)     cnt_nxt = '0;
    else if (adv_i) cnt_nxt = cnt_q + 1'b1;
    else            cnt_nxt = cnt_q;
  end

  assign eff_addr_o = {base_nxt[HI:BURST_BITS],
                       burst_step(base_nxt[BURST_BITS-1:0], cnt_nxt, interleave_i)};
  assign addr_o     = {base_q[HI:BURST_BITS],
                       burst_step(base_q[BURST_BITS-1:0], cnt_q, interleave_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  a_r11_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(addr_o) || !$stable(interleave_i)));
  a_r10_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[HI:BURST_BITS]));
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram import pbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      adsp_ni,
  input  logic                      adsc_ni,
  input  logic                      adv_ni,
  input  logic                      gw_ni,
  input  logic                      bwe_ni,
  input  logic [LANES-1:0]          bw_ni,
  input  logic                      ce_ni,
  input  logic                      ce2_i,
  input  logic                      ce2_ni,
  input  logic                      oe_ni,
  input  logic                      mode_i,
  input  logic                      zz_i,
  input  logic [LANE_W*LANES-1:0]   data_i,
  output logic [LANE_W*LANES-1:0]   data_o,
  output logic                      data_vld_o
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [LANES-1:0]  lane_we;
  logic              blocked;
  logic [ADDR_W-1:0] eff_addr, cur_addr;
  logic              p_strobe, c_strobe, strobe, ce_ok;
  logic              start, desel, cont, wr_req, is_write, is_read, adv_en;
  logic              active_q, rd_q, dvld_q;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] mem [DEPTH];

  pbs_write_dec #(.LANES(LANES)) u_dec (
    .gw_ni  (gw_ni),
    .bwe_ni (bwe_ni),
    .bw_ni  (bw_ni),
    .we_o   (lane_we)
  );

  pbs_snooze u_zz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zz_i      (zz_i),
    .blocked_o (blocked)
  );

  pbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start),
    .base_i       (addr_i),
    .adv_i        (adv_en),
    .interleave_i (mode_i),
    .eff_addr_o   (eff_addr),
    .addr_o       (cur_addr)
  );

  // primary enable masks the processor strobe
  always_comb begin
    p_strobe = !adsp_ni && !ce_ni;
    c_strobe = !adsc_ni && !p_strobe;
    strobe   = p_strobe || c_strobe;
    ce_ok    = !ce_ni && ce2_i && !ce2_ni;
    start    = !blocked && strobe && ce_ok;
    desel    = !blocked && strobe && !ce_ok;
    cont     = !blocked && !strobe && active_q;
    wr_req   = |lane_we;
    is_write = ((start && c_strobe) || cont) && wr_req;
    is_read  = (start && (p_strobe || !wr_req)) || (cont && !wr_req);
    adv_en   = cont && !adv_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (is_write) begin
      for (int l = 0; l < LANES; l++)
        if (lane_we[l]) mem[eff_addr][l*LANE_W +: LANE_W] <= data_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      dvld_q   <= 1'b0;
      dout_q   <= '0;
    end else begin
      if (blocked || desel) active_q <= 1'b0;
      else if (start)       active_q <= 1'b1;
      rd_q   <= is_read;
      dvld_q <= rd_q && !blocked;
      dout_q <= mem[cur_addr];
    end
  end

  assign data_vld_o = dvld_q && !oe_ni;
  assign data_o     = data_vld_o ? dout_q : '0;

  a_r9_valid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvld_q |-> $past(rd_q));
  a_r2_desel_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel |=> !rd_q);
  a_r7_read_no_lane_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && (bwe_ni || (&bw_ni))) |-> (lane_we == '0));
  a_r13_blocked_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> !rd_q);
endmodule

// File: tb/pipe_burst_sram_tb.sv
module pipe_burst_sram_tb;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0, oe_n = 1'b0, mode = 1'b0, zz = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dvld;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_ni(adsp_n), .adsc_ni(adsc_n),
    .adv_ni(adv_n), .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .ce_ni(ce_n),
    .ce2_i(ce2), .ce2_ni(ce2_n), .oe_ni(oe_n), .mode_i(mode), .zz_i(zz),
    .data_i(din), .data_o(dout), .data_vld_o(dvld)
  );

  // reference model state
  logic [DW-1:0] m_mem [64];
  int m_zst = 0, m_zcnt = 0, m_base = 0, m_cnt = 0;
  bit m_active = 0, m_rd = 0, m_dvld = 0;
  logic [DW-1:0] m_dout = '0;

  function automatic int m_addr(int base, int cnt);
    int lo;
    lo = mode ? ((base % 4) ^ cnt) : (((base % 4) + cnt) % 4);
    return base - (base % 4) + lo;
  endfunction

  task automatic m_write(int a);
    logic [NL-1:0] wm;
    if (!gw_n) wm = '1;
    else if (!bwe_n) wm = ~bw_n;
    else wm = '0;
    for (int l = 0; l < NL; l++)
      if (wm[l]) m_mem[a][l*LW +: LW] = din[l*LW +: LW];
  endtask

  task automatic m_step();
    bit blk, p, c, ok, wr, rd;
    logic [DW-1:0] nd;
    blk = (m_zst >= 2);
    nd = m_mem[m_addr(m_base, m_cnt)];
    wr = !gw_n || (!bwe_n && bw_n != '1);
    p = !adsp_n && !ce_n;
    c = !adsc_n && !p;
    ok = !ce_n && ce2 && !ce2_n;
    rd = 0;
    m_dvld = m_rd && !blk;
    if (blk) m_active = 0;
    else if (p || c) begin
      if (ok) begin
        m_base = int'(addr); m_cnt = 0; m_active = 1;
        if (c && wr) m_write(m_base); else rd = 1;
      end else m_active = 0;
    end else if (m_active) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      if (wr) m_write(m_addr(m_base, m_cnt)); else rd = 1;
    end
    m_rd = rd;
    m_dout = nd;
    case (m_zst)
      0: if (zz) begin m_zst = 1; m_zcnt = 1; end
      1: if (!zz) m_zst = 0; else if (m_zcnt >= 1) m_zst = 2; else m_zcnt++;
      2: if (!zz) begin m_zst = 3; m_zcnt = 1; end
      default: if (zz) m_zst = 2; else if (m_zcnt >= 1) m_zst = 0; else m_zcnt++;
    endcase
  endtask

  task automatic compare();
    bit ev;
    logic [DW-1:0] ed;
    ev = m_dvld && !oe_n;
    ed = ev ? m_dout : '0;
    n_chk++;
    if (dvld !== ev || dout !== ed) begin
      n_err++;
      $display("FAIL %s vld=%0b data=%h expected vld=%0b data=%h at %0t",
               cur_req, dvld, dout, ev, ed, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      m_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce_n = 0; ce2 = 1; ce2_n = 0;
  endtask

  task automatic end_burst();
    idle(); adsc_n = 0; ce2 = 0; cyc(1); idle(); cyc(2);
  endtask

  task automatic c_start(int a, bit g, bit b, logic [NL-1:0] bw, logic [DW-1:0] d);
    idle(); addr = AW'(a); adsc_n = 0; gw_n = g; bwe_n = b; bw_n = bw; din = d; cyc(1);
  endtask

  task automatic p_start(int a);
    idle(); addr = AW'(a); adsp_n = 0; cyc(1);
  endtask

  task automatic step_burst(bit adv, bit g, logic [DW-1:0] d);
    idle(); adv_n = ~adv; gw_n = g; din = d; cyc(1);
  endtask

  task automatic rd_one(int a);
    c_start(a, 1, 1, '1, '0); idle(); cyc(2); end_burst();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare();
    rst_n = 1;
    cyc(2);

    // global and lane writes, then read back
    cur_req = "R5"; c_start(4, 0, 1, '1, 36'h1_2345_6789); end_burst();
    rd_one(4);
    cur_req = "R6"; c_start(4, 1, 0, 4'b1101, 36'hF_FFFF_FFFF); end_burst();
    rd_one(4);
    c_start(4, 1, 0, 4'b0110, 36'h0_0000_0000); end_burst();
    rd_one(4);
    cur_req = "R7"; c_start(4, 1, 0, 4'b1111, 36'hA_AAAA_AAAA); idle(); cyc(2); end_burst();
    rd_one(4);

    // linear burst write 8..11, continued writes at advanced address
    cur_req = "R8"; mode = 0;
    c_start(8, 0, 1, '1, 36'h0_0000_0108);
    for (int k = 1; k < 4; k++) step_burst(1, 0, DW'(36'h100 + 8 + k));
    end_burst();
    cur_req = "R10";
    c_start(10, 1, 1, '1, '0);
    for (int k = 0; k < 4; k++) step_burst(1, 1, '0);
    end_burst();
    mode = 1; cyc(1);
    c_start(9, 1, 1, '1, '0);
    for (int k = 0; k < 4; k++) step_burst(1, 1, '0);
    end_burst();
    mode = 0; cyc(1);

    // suspend with output enable toggling
    cur_req = "R11"; c_start(8, 1, 1, '1, '0);
    step_burst(0, 1, '0); step_burst(0, 1, '0); step_burst(1, 1, '0); step_burst(0, 1, '0);
    cur_req = "R12"; oe_n = 1; #1 compare(); step_burst(0, 1, '0); oe_n = 0; #1 compare();
    step_burst(1, 1, '0);
    end_burst();
    cur_req = "R9"; rd_one(11);

    // processor strobe forces read, write follows next cycle
    cur_req = "R4"; idle(); addr = 6'd12; adsp_n = 0; gw_n = 0; din = 36'h7_7777_7777; cyc(1);
    idle(); cyc(2); end_burst(); rd_one(12);
    idle(); addr = 6'd8; adsp_n = 0; ce_n = 1; adsc_n = 1; cyc(2); idle(); cyc(2);
    cur_req = "R8"; p_start(13); step_burst(0, 0, 36'h3_3333_3333); idle(); cyc(2); end_burst();
    rd_one(13);

    // deselect cases
    cur_req = "R2"; c_start(8, 1, 1, '1, '0); idle(); cyc(1);
    idle(); adsc_n = 0; ce_n = 1; cyc(3);
    c_start(8, 1, 1, '1, '0); idle(); adsc_n = 0; ce2_n = 1; cyc(3);
    p_start(9); idle(); adsp_n = 0; ce2 = 0; cyc(3);
    c_start(9, 0, 1, '1, 36'h5); idle(); adsc_n = 0; ce2_n = 1; gw_n = 0; din = 36'h9; cyc(2);
    idle(); cyc(1); rd_one(9);

    // secondaries ignored mid-burst
    cur_req = "R3"; c_start(8, 1, 1, '1, '0);
    idle(); adv_n = 0; ce2 = 0; ce2_n = 1; cyc(3);
    idle(); ce_n = 1; adv_n = 0; cyc(2);
    end_burst();

    // snooze
    cur_req = "R13"; c_start(4, 1, 1, '1, '0);
    zz = 1; idle(); cyc(3);
    c_start(4, 0, 1, '1, 36'hB_BBBB_BBBB); idle(); cyc(3);
    zz = 0; c_start(4, 0, 1, '1, 36'hC_CCCC_CCCC); c_start(5, 0, 1, '1, 36'hD_DDDD_DDDD);
    c_start(6, 0, 1, '1, 36'hE_EEEE_EEEE); end_burst();
    rd_one(4); rd_one(5); rd_one(6);
    zz = 1; cyc(1); zz = 0; cyc(1); rd_one(6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule